// File: doc/BRIEF.md
# Overlapping Serial Pattern Detector

This block watches a one-bit serial stream and raises a detect flag every time the five-bit sequence 0, 1, 1, 1, 0 has arrived, oldest bit first. Occurrences may share bits: the closing 0 of one hit serves as the opening 0 of the next, so the stream 011101110 yields two detections.

Every register runs on a single fast clock, 100 MHz in the intended use. A prescaler divides that clock into a one-cycle enable tick, which gives 10 kHz at the default count of 10000. The input is sampled only on that tick, and the state machine advances only on it. No derived clock is built. After each hit the flag stays high for a parameterised number of sample periods, two by default. A one-hot debug vector shows which of the five match states is active.

Top module: `serial_pattern_watch`

## Requirements
- R1: The detect flag rises at the clock edge of the tick on which a 0 is sampled directly after the sampled run 0,1,1,1. No other five-sample run produces a detection.
- R2: Hits may overlap. After a hit the next state is the "0 seen" state, so 011101110 produces two detections, four sample periods apart.
- R3: After a hit, `detect` stays high for exactly HOLD_TICKS sample periods (default 2). It falls at the edge of the HOLD_TICKS-th tick after the hit.
- R4: A hit that arrives while `detect` is still high restarts the full HOLD_TICKS hold from that hit.
- R5: The enable tick is high for exactly one clock in every TICK_DIV clocks. The first tick comes on the TICK_DIV-th clock edge after reset is released. The state and the flag change only on tick edges.
- R6: `state_dbg` is one-hot. Bit 0 means nothing matched, bit 1 means "0", bit 2 means "01", bit 3 means "011" and bit 4 means "0111".
- R7: On a mismatch the machine falls back. A 1 with nothing matched stays in the empty state. A sampled 0 in any state other than the fourth-bit state leads to the "0" state. A 1 in the "0111" state leads to the empty state.
- R8: Reset is active high and synchronous. It sets `state_dbg` to the empty state, clears `detect` and clears the prescaler, even in the middle of a sample period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| serial_in | input | 1 | Serial data, sampled on each enable tick |
| detect | output | 1 | Stretched detection flag |
| state_dbg | output | 5 | One-hot debug view of the match state |

## Verification
On every cycle the assertions check four things: the tick never lasts two cycles, the state and the flag hold still between ticks, every hit lands in the "0" state with the flag high, and reset always yields the empty state with the flag clear. The sequence of states, the overlapping double detection, the exact length of the flag and the hold restart by a close second hit can only be shown by the bench's scenarios. The same goes for the prescaler restarting after a reset in the middle of a period. To show the hold restart, a second instance with a long hold runs on the same stream.

// File: rtl/spw_pkg.sv
package spw_pkg;

   localparam int SPW_NUM_STATES = 5;

   typedef enum logic [2:0] {
      ST_NONE  = 3'd0,
      ST_Z     = 3'd1,
      ST_ZO    = 3'd2,
      ST_ZOO   = 3'd3,
      ST_ZOOO  = 3'd4
   } spw_state_e;

   typedef struct packed {
      spw_state_e nxt;
      logic       hit;
   } spw_step_t;

   // One sample step of the 0-1-1-1-0 matcher; a hit re-enters ST_Z (overlap)
   function automatic spw_step_t spw_advance(input spw_state_e cur, input logic b);
      spw_step_t r;
      r.hit = 1'b0;
      r.nxt = ST_NONE;
      unique case (cur)
         ST_NONE: r.nxt = b ? ST_NONE : ST_Z;
         ST_Z:    r.nxt = b ? ST_ZO   : ST_Z;
         ST_ZO:   r.nxt = b ? ST_ZOO  : ST_Z;
         ST_ZOO:  r.nxt = b ? ST_ZOOO : ST_Z;
         ST_ZOOO: begin
            r.nxt = b ? ST_NONE : ST_Z;
            r.hit = ~b;
         end
         default: r.nxt = ST_NONE;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/spw_tick_gen.sv
module spw_tick_gen #(
   parameter int TICK_DIV = 10000
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

   initial begin
      assert (TICK_DIV >= 2) else $error("TICK_DIV must be at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)              cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

   assign tick = (cnt == LAST);

   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);   // R5
   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
      cnt <= LAST);      // R5
endmodule

// File: rtl/spw_seq_fsm.sv
module spw_seq_fsm
   import spw_pkg::*;
#(
   parameter bit ONEHOT_REG = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      tick,
   input  logic                      bit_in,
   output logic                      hit,
   output logic [SPW_NUM_STATES-1:0] state_dbg
);
   spw_state_e cur;
   spw_step_t  step;

   assign step = spw_advance(cur, bit_in);
   assign hit  = tick & step.hit;

   generate
      if (ONEHOT_REG) begin : g_onehot
         logic [SPW_NUM_STATES-1:0] oh;
         always_ff @(posedge clk) begin
            if (rst)       oh <= SPW_NUM_STATES'(1);
            else if (tick) oh <= SPW_NUM_STATES'(1) << step.nxt;
         end
         always_comb begin
            cur = ST_NONE;
            for (int i = SPW_NUM_STATES - 1; i >= 0; i--)
               if (oh[i]) cur = spw_state_e'(i);
         end
         assign state_dbg = oh;
      end else begin : g_encoded
         spw_state_e enc;
         always_ff @(posedge clk) begin
            if (rst)       enc <= ST_NONE;
            else if (tick) enc <= step.nxt;
         end
         assign cur       = enc;
         assign state_dbg = SPW_NUM_STATES'(1) << enc;
      end
   endgenerate

   AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(state_dbg));          // R5
   AST_HIT_TO_ZERO_SEEN: assert property (@(posedge clk) disable iff (rst)
      hit |=> (state_dbg == 5'b00010));        // R2
   AST_DBG_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      tick |=> ($countones(state_dbg) == 1));  // R6
endmodule

// File: rtl/spw_hold_stretch.sv
module spw_hold_stretch #(
   parameter int HOLD_TICKS = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic hit,
   output logic flag
);
   localparam int HW = $clog2(HOLD_TICKS + 1);
   localparam logic [HW-1:0] RELOAD = HW'(HOLD_TICKS);

   initial begin
      assert (HOLD_TICKS >= 1) else $error("HOLD_TICKS must be at least 1");
   end

   logic [HW-1:0] left;

   always_ff @(posedge clk) begin
      if (rst)                       left <= '0;
      else if (hit)                  left <= RELOAD;
      else if (tick && left != '0)   left <= left - 1'b1;
   end

   assign flag = (left != '0);

   AST_HIT_RAISES_FLAG: assert property (@(posedge clk) disable iff (rst)
      hit |=> flag);                            // R3
   AST_FLAG_STEADY: assert property (@(posedge clk) disable iff (rst)
      (!tick && !hit) |=> $stable(flag));       // R3
endmodule

// File: rtl/serial_pattern_watch.sv
module serial_pattern_watch
   import spw_pkg::*;
#(
   parameter int TICK_DIV   = 10000,
   parameter int HOLD_TICKS = 2,
   parameter bit ONEHOT_REG = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       serial_in,
   output logic       detect,
   output logic [4:0] state_dbg
);
   initial begin
      assert (SPW_NUM_STATES == 5) else $error("state count mismatch");
   end

   logic tick;
   logic hit;

   spw_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst(rst), .tick(tick));

   spw_seq_fsm #(.ONEHOT_REG(ONEHOT_REG)) u_fsm (
      .clk(clk), .rst(rst), .tick(tick), .bit_in(serial_in),
      .hit(hit), .state_dbg(state_dbg));

   spw_hold_stretch #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
      .clk(clk), .rst(rst), .tick(tick), .hit(hit), .flag(detect));

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (state_dbg == 5'b00001 && !detect));   // R8
endmodule

// File: tb/serial_pattern_watch_test.sv
module serial_pattern_watch_test;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic serial_in = 1'b1;
   logic detect, detect_long;
   logic [4:0] state_dbg, state_long;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_pattern_watch #(.TICK_DIV(DIV), .HOLD_TICKS(2)) uut (
      .clk(clk), .rst(rst), .serial_in(serial_in),
      .detect(detect), .state_dbg(state_dbg));

   serial_pattern_watch #(.TICK_DIV(DIV), .HOLD_TICKS(6), .ONEHOT_REG(1'b0)) uut_long (
      .clk(clk), .rst(rst), .serial_in(serial_in),
      .detect(detect_long), .state_dbg(state_long));

   typedef struct packed {
      logic       x;
      logic [4:0] st;
      logic       fl;
      logic       fll;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 5'b00010, 1'b0, 1'b0},
      '{1'b1, 5'b00100, 1'b0, 1'b0},
      '{1'b1, 5'b01000, 1'b0, 1'b0},
      '{1'b1, 5'b10000, 1'b0, 1'b0},
      '{1'b0, 5'b00010, 1'b1, 1'b1},
      '{1'b1, 5'b00100, 1'b1, 1'b1},
      '{1'b1, 5'b01000, 1'b0, 1'b1},
      '{1'b1, 5'b10000, 1'b0, 1'b1},
      '{1'b0, 5'b00010, 1'b1, 1'b1},
      '{1'b1, 5'b00100, 1'b1, 1'b1},
      '{1'b1, 5'b01000, 1'b0, 1'b1},
      '{1'b1, 5'b10000, 1'b0, 1'b1},
      '{1'b1, 5'b00001, 1'b0, 1'b1},
      '{1'b1, 5'b00001, 1'b0, 1'b1},
      '{1'b0, 5'b00010, 1'b0, 1'b0},
      '{1'b0, 5'b00010, 1'b0, 1'b0},
      '{1'b1, 5'b00100, 1'b0, 1'b0},
      '{1'b0, 5'b00010, 1'b0, 1'b0},
      '{1'b1, 5'b00100, 1'b0, 1'b0},
      '{1'b1, 5'b01000, 1'b0, 1'b0},
      '{1'b0, 5'b00010, 1'b0, 1'b0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // one sample period: drive, wait DIV edges, sample just after the tick edge
   task automatic step(input logic x);
      serial_in = x;
      repeat (DIV) @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R8 reset state", state_dbg, 5'b00001);
      chk("R8 reset flag", detect, 0);
      chk("R6 reset state encoded variant", state_long, 5'b00001);
      rst = 1'b0;

      // R1 R2 R3 R4 R6 R7: table walk, overlapping hits and fall-backs
      for (int i = 0; i < NV; i++) begin
         step(VEC[i].x);
         chk($sformatf("R1/R7 state step %0d", i + 1), state_dbg, VEC[i].st);
         chk($sformatf("R2/R3 flag step %0d", i + 1), detect, VEC[i].fl);
         chk($sformatf("R4 long flag step %0d", i + 1), detect_long, VEC[i].fll);
         chk($sformatf("R6 encoded state step %0d", i + 1), state_long, VEC[i].st);
      end

      // Build a hit, then reset in mid period: R8
      step(1'b1); step(1'b1); step(1'b1); step(1'b0);
      chk("R1 hit before reset", detect, 1);
      serial_in = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      rst = 1'b1;
      @(posedge clk);
      #1;
      chk("R8 mid-period reset state", state_dbg, 5'b00001);
      chk("R8 mid-period reset flag", detect, 0);
      chk("R8 mid-period reset long flag", detect_long, 0);
      rst = 1'b0;

      // Prescaler restarted: first tick exactly DIV edges after release (R5, R8)
      serial_in = 1'b0;
      repeat (DIV - 1) @(posedge clk);
      #1;
      chk("R5 no advance before tick", state_dbg, 5'b00001);
      @(posedge clk);
      #1;
      chk("R5 advance on first tick", state_dbg, 5'b00010);
      serial_in = 1'b1;
      repeat (DIV - 1) @(posedge clk);
      #1;
      chk("R5 state steady between ticks", state_dbg, 5'b00010);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule